// File: doc/BRIEF.md
# Token-Bus Byte Pulse Serializer

This block converts a packet, presented one byte at a time on a valid/ready stream, into the pulse-coded line signal of a token-passing bus. Each byte is stretched over a fixed frame of eleven bit cells. A cell that carries a one produces a negative pulse on the line output lasting half a cell. A cell that carries a zero leaves the line at its idle, spacing level. Bit cells are paced by an external one-clock cell tick, so the same block serves any line rate the tick is derived for.

While a packet streams in, the block accumulates a 16-bit CRC with generator x^16 + x^15 + x^2 + 1. After the byte flagged as last, it sends the two CRC bytes in the same eleven-cell format. An active-low transmit enable frames the whole burst for the external line driver. The packet content (header bytes, the count byte and the data) is the upstream logic's concern. The block treats every streamed byte alike.

Top module: `token_pulse_serializer`

## Requirements
- R1: While `rst_n` is low and after it rises, `line_n` and `tx_en_n` are high and `s_ready` is high.
- R2: Every byte occupies exactly 11 cells: cells 0 and 1 carry a one, cell 2 carries a zero, and cells 3 to 10 carry data bits 0 to 7 in that order (least significant bit first). A cell starts at the clock edge where `cell_tick` is high.
- R3: A one cell drives `line_n` low from the edge that starts the cell for exactly CELL_CLKS/2 clock cycles. A zero cell leaves `line_n` high for the whole cell.
- R4: `tx_en_n` falls at the start of one spacing cell that precedes the first byte's cell 0. It rises at the start of the final cell of the packet (cell 10 of the second CRC byte). That final cell still produces its pulse.
- R5: After the last data byte, two CRC bytes follow, the high byte first. The CRC register starts at 0x0000. Data bits enter it in transmission order: feedback = crc[15] XOR bit, then crc = (crc << 1) XOR (feedback ? 0x8005 : 0).
- R6: The block holds at most one byte ahead of the one being sent. `s_ready` is low on the cycle after each accepted byte. After the byte with `s_last` is accepted, `s_ready` stays low until the packet's final cell has ended.
- R7: If no byte is waiting when a data byte's cell 10 ends, and that byte was not the last, the block sends spacing cells with `tx_en_n` held low until a byte arrives. The next byte then starts on a cell boundary.
- R8: After a packet ends, the line spends at least one idle cell with `tx_en_n` high. The next packet then starts with its own enable cell, and its CRC starts again from 0x0000.
- R9: `line_n` falls and `tx_en_n` changes only on clock edges where `cell_tick` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_tick | input | 1 | One-clock pulse every CELL_CLKS clocks marking a bit-cell boundary |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the final byte of a packet |
| s_ready | output | 1 | Block can accept a byte |
| line_n | output | 1 | Active-low line pulse |
| tx_en_n | output | 1 | Active-low transmit enable |

## Verification
The embedded properties hold every cycle for these points: the cell index stays inside the byte frame, a line pulse begins and the enable moves only on a tick edge, the enable is already off when a packet closes, the enable stays on through spacing cells, and the stream is refused right after each handshake. Whether the right bit lands in the right cell, the CRC values, the placement of the enable edges, and the gap behaviour across packets cannot be expressed as local invariants. The bench's behavioural line model shows them by comparing both outputs on every clock across single-byte, multi-byte, underrun and back-to-back packets.

// File: rtl/tbps_pkg.sv
package tbps_pkg;

   localparam int unsigned BYTE_W     = 8;
   localparam int unsigned LEAD_CELLS = 3;
   localparam int unsigned LINE_CELLS = LEAD_CELLS + BYTE_W;
   localparam int unsigned CELL_IDX_W = $clog2(LINE_CELLS);
   localparam int unsigned CRC_W      = 2 * BYTE_W;
   localparam int unsigned BIT_SEL_W  = $clog2(BYTE_W);

   // bit i is the value of lead-in cell i
   localparam logic [LEAD_CELLS-1:0] LEAD_PATTERN = 3'b011;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_LEAD = 2'd1,
      SEQ_BYTE = 2'd2,
      SEQ_GAP  = 2'd3
   } seq_state_t;

   typedef enum logic [1:0] {
      SRC_DATA   = 2'd0,
      SRC_CRC_HI = 2'd1,
      SRC_CRC_LO = 2'd2
   } byte_src_t;

   function automatic logic cell_value(input logic [CELL_IDX_W-1:0] idx,
                                       input logic [BYTE_W-1:0]     payload);
      logic [BIT_SEL_W-1:0] sel;
      logic                 v;
      sel = BIT_SEL_W'(idx - CELL_IDX_W'(LEAD_CELLS));
      if (idx < CELL_IDX_W'(LEAD_CELLS)) v = LEAD_PATTERN[idx[1:0]];
      else                               v = payload[sel];
      return v;
   endfunction

endpackage

// File: rtl/tbps_crc_step.sv
module tbps_crc_step #(
   parameter int unsigned         CRC_W  = 16,
   parameter int unsigned         DATA_W = 8,
   parameter logic [CRC_W-1:0]    POLY   = 16'h8005
) (
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [DATA_W-1:0] data_in,
   output logic [CRC_W-1:0]  crc_out
);

   if (CRC_W < 2)  begin : g_bad_crc_w  $error("CRC_W must be at least 2");  end
   if (DATA_W < 1) begin : g_bad_data_w $error("DATA_W must be at least 1"); end

   logic [CRC_W-1:0] stage [DATA_W+1];

   assign stage[0] = crc_in;

   // one shift stage per data bit, bit 0 enters first
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic fb;
      assign fb           = stage[i][CRC_W-1] ^ data_in[i];
      assign stage[i+1]   = {stage[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   assign crc_out = stage[DATA_W];

endmodule

// File: rtl/tbps_hold_buffer.sv
module tbps_hold_buffer #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_valid,
   input  logic [DATA_W-1:0] s_data,
   input  logic              s_last,
   output logic              s_ready,
   input  logic              take,
   input  logic              frame_done,
   output logic              hold_full,
   output logic [DATA_W-1:0] hold_data,
   output logic              hold_last
);

   logic last_taken;
   logic accept;

   assign s_ready = !hold_full && !last_taken;
   assign accept  = s_valid && s_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_full  <= 1'b0;
         hold_data  <= '0;
         hold_last  <= 1'b0;
         last_taken <= 1'b0;
      end else begin
         if (accept) begin
            hold_full <= 1'b1;
            hold_data <= s_data;
            hold_last <= s_last;
         end else if (take) begin
            hold_full <= 1'b0;
         end
         if (accept && s_last)  last_taken <= 1'b1;
         else if (frame_done)   last_taken <= 1'b0;
      end
   end

   // R6
   refuse_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_ready) |=> !s_ready);

   // R6
   take_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> hold_full);

endmodule

// File: rtl/tbps_cell_sequencer.sv
module tbps_cell_sequencer
   import tbps_pkg::*;
#(
   parameter logic [CRC_W-1:0] CRC_POLY = 16'h8005,
   parameter logic [CRC_W-1:0] CRC_INIT = 16'h0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cell_tick,
   input  logic              hold_full,
   input  logic [BYTE_W-1:0] hold_data,
   input  logic              hold_last,
   output logic              take,
   output logic              frame_done,
   output logic              fire,
   output logic              tx_en_n
);

   localparam logic [CELL_IDX_W-1:0] LAST_IDX = CELL_IDX_W'(LINE_CELLS - 1);

   seq_state_t              state, nxt_state;
   byte_src_t               src, nxt_src;
   logic [CELL_IDX_W-1:0]   idx, nxt_idx, idx_inc;
   logic [BYTE_W-1:0]       sh, nxt_sh;
   logic [CRC_W-1:0]        crc, nxt_crc, crc_stepped;
   logic                    cur_last, nxt_last;
   logic                    en, nxt_en;
   logic                    nxt_pulse;
   logic                    at_boundary;

   tbps_crc_step #(
      .CRC_W  (CRC_W),
      .DATA_W (BYTE_W),
      .POLY   (CRC_POLY)
   ) u_crc (
      .crc_in  (crc),
      .data_in (hold_data),
      .crc_out (crc_stepped)
   );

   assign idx_inc     = idx + 1'b1;
   assign at_boundary = cell_tick &&
                        ((state == SEQ_LEAD) || (state == SEQ_GAP) ||
                         ((state == SEQ_BYTE) && (idx == LAST_IDX)));

   always_comb begin
      nxt_state  = state;
      nxt_src    = src;
      nxt_idx    = idx;
      nxt_sh     = sh;
      nxt_crc    = crc;
      nxt_last   = cur_last;
      nxt_en     = en;
      nxt_pulse  = 1'b0;
      take       = 1'b0;
      frame_done = 1'b0;
      if (at_boundary) begin
         if (state == SEQ_BYTE && src == SRC_CRC_LO) begin
            nxt_state  = SEQ_IDLE;
            nxt_en     = 1'b0;
            nxt_crc    = CRC_INIT;
            nxt_last   = 1'b0;
            frame_done = 1'b1;
         end else if (state == SEQ_BYTE && src == SRC_CRC_HI) begin
            nxt_state = SEQ_BYTE;
            nxt_src   = SRC_CRC_LO;
            nxt_sh    = crc[BYTE_W-1:0];
            nxt_idx   = '0;
            nxt_pulse = cell_value('0, crc[BYTE_W-1:0]);
            nxt_en    = 1'b1;
         end else if (state == SEQ_BYTE && cur_last) begin
            nxt_state = SEQ_BYTE;
            nxt_src   = SRC_CRC_HI;
            nxt_sh    = crc[CRC_W-1:BYTE_W];
            nxt_idx   = '0;
            nxt_pulse = cell_value('0, crc[CRC_W-1:BYTE_W]);
            nxt_en    = 1'b1;
         end else if (hold_full) begin
            nxt_state = SEQ_BYTE;
            nxt_src   = SRC_DATA;
            nxt_sh    = hold_data;
            nxt_crc   = crc_stepped;
            nxt_last  = hold_last;
            nxt_idx   = '0;
            nxt_pulse = cell_value('0, hold_data);
            nxt_en    = 1'b1;
            take      = 1'b1;
         end else begin
            nxt_state = SEQ_GAP;
            nxt_en    = 1'b1;
         end
      end else if (cell_tick) begin
         if (state == SEQ_IDLE) begin
            if (hold_full) begin
               nxt_state = SEQ_LEAD;
               nxt_en    = 1'b1;
            end
         end else if (state == SEQ_BYTE) begin
            nxt_idx   = idx_inc;
            nxt_pulse = cell_value(idx_inc, sh);
            nxt_en    = !((src == SRC_CRC_LO) && (idx_inc == LAST_IDX));
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= SEQ_IDLE;
         src      <= SRC_DATA;
         idx      <= '0;
         sh       <= '0;
         crc      <= CRC_INIT;
         cur_last <= 1'b0;
         en       <= 1'b0;
      end else begin
         state    <= nxt_state;
         src      <= nxt_src;
         idx      <= nxt_idx;
         sh       <= nxt_sh;
         crc      <= nxt_crc;
         cur_last <= nxt_last;
         en       <= nxt_en;
      end
   end

   assign fire    = cell_tick && nxt_pulse;
   assign tx_en_n = !en;

   // R2
   cell_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= LAST_IDX);

   // R9
   en_at_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tx_en_n) |-> $past(cell_tick));

   // R4
   en_off_before_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> tx_en_n);

   // R7
   gap_keeps_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_GAP) |-> !tx_en_n);

endmodule

// File: rtl/tbps_pulse_shaper.sv
module tbps_pulse_shaper #(
   parameter int unsigned CELL_CLKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic line_n
);

   localparam int unsigned HALF  = CELL_CLKS / 2;
   localparam int unsigned CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

   if (CELL_CLKS < 2) begin : g_bad_cell $error("CELL_CLKS must be at least 2"); end

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_n <= 1'b1;
         remain <= '0;
      end else if (fire) begin
         line_n <= 1'b0;
         remain <= CNT_W'(HALF - 1);
      end else if (remain != '0) begin
         remain <= remain - 1'b1;
      end else begin
         line_n <= 1'b1;
      end
   end

   // R3
   pulse_starts_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(line_n) |-> $past(fire));

endmodule

// File: rtl/token_pulse_serializer.sv
module token_pulse_serializer
   import tbps_pkg::*;
#(
   parameter int unsigned      CELL_CLKS = 4,
   parameter logic [CRC_W-1:0] CRC_POLY  = 16'h8005,
   parameter logic [CRC_W-1:0] CRC_INIT  = 16'h0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cell_tick,
   input  logic              s_valid,
   input  logic [BYTE_W-1:0] s_data,
   input  logic              s_last,
   output logic              s_ready,
   output logic              line_n,
   output logic              tx_en_n
);

   if (CELL_CLKS < 2) begin : g_bad_cell_clks $error("CELL_CLKS must be at least 2"); end

   logic              hold_full;
   logic [BYTE_W-1:0] hold_data;
   logic              hold_last;
   logic              take;
   logic              frame_done;
   logic              fire;

   tbps_hold_buffer #(
      .DATA_W (BYTE_W)
   ) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .s_valid    (s_valid),
      .s_data     (s_data),
      .s_last     (s_last),
      .s_ready    (s_ready),
      .take       (take),
      .frame_done (frame_done),
      .hold_full  (hold_full),
      .hold_data  (hold_data),
      .hold_last  (hold_last)
   );

   tbps_cell_sequencer #(
      .CRC_POLY (CRC_POLY),
      .CRC_INIT (CRC_INIT)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cell_tick  (cell_tick),
      .hold_full  (hold_full),
      .hold_data  (hold_data),
      .hold_last  (hold_last),
      .take       (take),
      .frame_done (frame_done),
      .fire       (fire),
      .tx_en_n    (tx_en_n)
   );

   tbps_pulse_shaper #(
      .CELL_CLKS (CELL_CLKS)
   ) u_shape (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (fire),
      .line_n (line_n)
   );

endmodule

// File: tb/sim_token_pulse_serializer.sv
module sim_token_pulse_serializer;

   localparam int CELL = 4;
   localparam int HALF = CELL / 2;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       cell_tick;
   logic       s_valid;
   logic [7:0] s_data;
   logic       s_last;
   logic       s_ready;
   logic       line_n;
   logic       tx_en_n;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   token_pulse_serializer #(.CELL_CLKS(CELL)) u0 (
      .clk(clk), .rst_n(rst_n), .cell_tick(cell_tick),
      .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
      .line_n(line_n), .tx_en_n(tx_en_n)
   );

   // cell tick pacing
   int tcnt;
   always @(negedge clk) begin
      if (!rst_n) begin
         tcnt      = 0;
         cell_tick = 1'b0;
      end else begin
         cell_tick = (tcnt == CELL - 1);
         tcnt      = (tcnt + 1) % CELL;
      end
   end

   // ---------------- behavioural line model ----------------
   bit         cq_p[$];
   bit         cq_e[$];
   string      cq_t[$];
   logic [7:0] mb[$];
   bit         ml[$];
   int         m_mode;        // 0 idle, 1 active
   bit         m_lastsent;
   bit         m_done;
   logic [15:0] m_crc;
   int         low_left;
   bit         m_en;
   string      m_tag;
   bit         edge_tick;

   function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
      for (int i = 0; i < 8; i++) begin
         logic fb;
         fb = c[15] ^ d[i];
         c  = {c[14:0], 1'b0};
         if (fb) c = c ^ 16'h8005;
      end
      return c;
   endfunction

   task automatic add_cells(input logic [7:0] d, input bit final_byte, input string tag);
      for (int k = 0; k < 11; k++) begin
         bit p;
         if (k < 2)       p = 1'b1;
         else if (k == 2) p = 1'b0;
         else             p = d[k-3];
         cq_p.push_back(p);
         cq_e.push_back(!(final_byte && k == 10));
         cq_t.push_back((final_byte && k == 10) ? "R4" : tag);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         cq_p.delete(); cq_e.delete(); cq_t.delete();
         mb.delete(); ml.delete();
         m_mode = 0; m_lastsent = 0; m_done = 0; m_crc = 16'h0000;
         low_left = 0; m_en = 0; m_tag = "R1"; edge_tick = 0;
      end else begin
         bit cp;
         cp = 0;
         edge_tick = cell_tick;
         if (cell_tick) begin
            if (m_mode == 0) begin
               if (mb.size() > 0) begin
                  m_mode = 1; m_en = 1; m_tag = "R4";
               end else begin
                  m_en = 0; m_tag = "R8";
               end
            end else if (cq_p.size() == 0 && m_done) begin
               m_mode = 0; m_done = 0; m_lastsent = 0; m_crc = 16'h0000;
               m_en = 0; m_tag = "R8";
            end else begin
               if (cq_p.size() == 0) begin
                  if (m_lastsent) begin
                     add_cells(m_crc[15:8], 1'b0, "R5");
                     add_cells(m_crc[7:0], 1'b1, "R5");
                     m_done = 1;
                  end else if (mb.size() > 0) begin
                     logic [7:0] d;
                     d = mb.pop_front();
                     m_lastsent = ml.pop_front();
                     m_crc = ref_crc(m_crc, d);
                     add_cells(d, 1'b0, "R2");
                  end
               end
               if (cq_p.size() > 0) begin
                  cp    = cq_p.pop_front();
                  m_en  = cq_e.pop_front();
                  m_tag = cq_t.pop_front();
               end else begin
                  m_en = 1; m_tag = "R7";
               end
            end
         end
         if (cell_tick && cp)  low_left = HALF;
         else if (low_left > 0) low_left = low_left - 1;
         if (s_valid && s_ready) begin
            mb.push_back(s_data);
            ml.push_back(s_last);
         end
      end
   end

   // ---------------- per-cycle comparison ----------------
   logic prev_line = 1'b1;
   logic prev_en_n = 1'b1;
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (line_n !== (low_left == 0)) begin
            fails++;
            $display("FAIL R3/%s line_n actual %b expected %b at %0t", m_tag, line_n, (low_left == 0), $time);
         end
         checks++;
         if (tx_en_n !== !m_en) begin
            fails++;
            $display("FAIL %s tx_en_n actual %b expected %b at %0t", m_tag, tx_en_n, !m_en, $time);
         end
         if ((prev_line && !line_n) || (prev_en_n !== tx_en_n)) begin
            checks++;
            if (!edge_tick) begin
               fails++;
               $display("FAIL R9 output moved off tick: actual tick=0 expected tick=1 at %0t", $time);
            end
         end
      end
      prev_line = line_n;
      prev_en_n = tx_en_n;
   end

   // ---------------- stimulus ----------------
   task automatic push(input logic [7:0] d, input bit l, input bit check_hold_last);
      s_data  = d;
      s_last  = l;
      s_valid = 1'b1;
      while (!s_ready) @(negedge clk);
      @(negedge clk);
      s_valid = 1'b0;
      checks++;
      if (s_ready !== 1'b0) begin
         fails++;
         $display("FAIL R6 s_ready after accept actual %b expected 0", s_ready);
      end
      if (check_hold_last) begin
         repeat (50) @(negedge clk);
         checks++;
         if (s_ready !== 1'b0) begin
            fails++;
            $display("FAIL R6 s_ready after last byte actual %b expected 0", s_ready);
         end
      end
   endtask

   task automatic wait_idle;
      do @(negedge clk); while (!(m_mode == 0 && mb.size() == 0 && cq_p.size() == 0));
      repeat (3 * CELL) @(negedge clk);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R8 watchdog: actual still running, expected finished");
      summary();
   end

   initial begin
      rst_n   = 1'b0;
      s_valid = 1'b0;
      s_data  = 8'h00;
      s_last  = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      checks++;
      if (line_n !== 1'b1) begin fails++; $display("FAIL R1 line_n actual %b expected 1", line_n); end
      checks++;
      if (tx_en_n !== 1'b1) begin fails++; $display("FAIL R1 tx_en_n actual %b expected 1", tx_en_n); end
      checks++;
      if (s_ready !== 1'b1) begin fails++; $display("FAIL R1 s_ready actual %b expected 1", s_ready); end
      rst_n = 1'b1;
      repeat (2 * CELL) @(negedge clk);

      // single zero byte: CRC of 0x00 from zero is zero (R5)
      push(8'h00, 1'b1, 1'b0);
      wait_idle();

      // ones and alternating bits (R2, R5)
      push(8'hFF, 1'b0, 1'b0);
      push(8'h55, 1'b0, 1'b0);
      push(8'h80, 1'b1, 1'b1);
      wait_idle();

      // upstream stalls longer than a byte: spacing cells (R7)
      push(8'h11, 1'b0, 1'b0);
      repeat (70) @(negedge clk);
      push(8'hA3, 1'b0, 1'b0);
      repeat (130) @(negedge clk);
      push(8'h3C, 1'b1, 1'b0);
      wait_idle();

      // back-to-back packets: idle cell, fresh CRC (R8)
      push(8'h01, 1'b0, 1'b0);
      push(8'hFE, 1'b1, 1'b1);
      push(8'h7E, 1'b0, 1'b0);
      push(8'hC9, 1'b1, 1'b0);
      push(8'h42, 1'b1, 1'b0);
      wait_idle();

      // quiet line after everything (R1, R8)
      checks++;
      if (line_n !== 1'b1 || tx_en_n !== 1'b1) begin
         fails++;
         $display("FAIL R8 idle line actual %b%b expected 11", line_n, tx_en_n);
      end
      summary();
   end

endmodule